// File: doc/BRIEF.md
# Broadcast Media Bus Node

This block is one node on a shared 32-bit bus that streams video words. Every word is broadcast to all nodes, and there is no acknowledge and no retry. A marker pin marks the cycle before a control word. A wired not-ready line lets any receiver hold back the current sender. Ownership of the bus passes from node to node by a command word that names the next owner.

On the transmit side a local valid/ready stream supplies the packet body. Once the node owns the bus, it opens the packet with a marker-only cycle and then a generated token word. It keeps one word in a holding register so that it can look at the next stream word and set the marker early. It raises a release bit on the last word. On the receive side the node watches every bus cycle, including its own. It tells control words from data words, follows destination selection and ownership hand-over, and presents addressed data words on a stream that has no backpressure.

Top module: `media_bus_node`

## Requirements
- R1: After reset all bus outputs are low, rx_valid and tx_ready are low, and owner_o equals the FIRST_OWNER parameter (default 1).
- R2: When owner_o equals my_id and tx_valid is high, the node first drives one cycle with bus_ctrl_o=1 and bus_valid_o=0. The next word it drives is a token word: bits [31:28]=4'h1, bits [27:4] zero, bits [3:0]=tx_next_id.
- R3: Each word the node drives has bus_ctrl_o=1 exactly when the next word of the same packet entered with tx_ctrl=1. The body words follow the token in stream order.
- R4: The word that entered with tx_last=1 is driven with bus_rel_o=1 and bus_ctrl_o=0. The cycle after it carries neither a word nor a marker.
- R5: On a clock edge where bus_nrdy_i is high, no word is launched, so bus_valid_o is low in the following cycle. No body word is lost or reordered by a stall.
- R6: While owner_o differs from my_id, the node drives no word and no marker, and tx_ready stays low.
- R7: A bus word is a control word when bus_ctrl_i was high on some cycle since the previous valid bus word, and a data word otherwise.
- R8: A control word with bits [31:28]=4'h2 sets the destination to bits [3:0]. Data words that follow while the destination equals my_id appear on rx_data with rx_valid one cycle later. Others are dropped.
- R9: A control word with bits [31:28]=4'h1 records bits [3:0] as the next owner, unless that value is 0. owner_o takes the recorded value on the edge that samples a valid word with bus_rel_i=1.
- R10: A release clears the destination, so data words after it are not delivered until a new select word arrives.
- R11: bus_nrdy_o is high only while the destination equals my_id and rx_ready is low. Addressed data words are still delivered while it is high.
- R12: Control words with any other opcode change neither the destination nor the next owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 4 | This node's ID (1 to 15) |
| tx_valid | input | 1 | Transmit stream word available |
| tx_data | input | 32 | Transmit stream word |
| tx_ctrl | input | 1 | The word is a control word |
| tx_last | input | 1 | Last word of the packet |
| tx_next_id | input | 4 | Owner named in the token of this packet |
| tx_ready | output | 1 | Transmit word taken this cycle |
| rx_valid | output | 1 | Addressed data word present |
| rx_data | output | 32 | Received data word |
| rx_ready | input | 1 | Local sink can take words |
| bus_data_i | input | 32 | Bus word seen |
| bus_valid_i | input | 1 | Bus cycle carries a word |
| bus_ctrl_i | input | 1 | Marker: next bus word is control |
| bus_rel_i | input | 1 | Current bus word ends the owner's packet |
| bus_nrdy_i | input | 1 | Wired not-ready from all nodes |
| bus_data_o | output | 32 | Word driven to bus |
| bus_valid_o | output | 1 | Driven cycle carries a word |
| bus_ctrl_o | output | 1 | Driven marker |
| bus_rel_o | output | 1 | Driven release |
| bus_nrdy_o | output | 1 | This node's not-ready |
| owner_o | output | 4 | Current bus owner ID |

## Verification
The assertions check on every cycle that no word leaves after a sampled not-ready, that only the owner launches words, and that the cycle after a release is empty. They also check that the first word after a marker cycle is a token, that the owner only moves on a release, that a release clears the destination, and that delivered words come from data cycles. Only the bench's scenarios can show the end-to-end effects. These are the exact marker placement across a packet and the body order kept through a stall. They also include which words reach rx_data under changing selection, the ignored zero-ID token, unknown opcodes, and ownership going round the ring to this node and away again.

// File: rtl/mbn_pkg.sv
package mbn_pkg;
  parameter int BUS_W  = 32;
  parameter int NODE_W = 4;
  parameter int OP_W   = 4;

  typedef logic [BUS_W-1:0]  word_t;
  typedef logic [NODE_W-1:0] node_t;
  typedef logic [OP_W-1:0]   op_t;

  localparam op_t OP_TOKEN  = op_t'(1);
  localparam op_t OP_SELECT = op_t'(2);

  typedef enum logic [1:0] {TX_IDLE, TX_TOKEN, TX_BODY, TX_GAP} tx_state_t;

  function automatic op_t opcode_of(word_t w);
    return w[BUS_W-1 -: OP_W];
  endfunction

  function automatic node_t id_of(word_t w);
    return w[NODE_W-1:0];
  endfunction

  function automatic word_t make_token(node_t id);
    word_t w;
    w = '0;
    w[BUS_W-1 -: OP_W] = OP_TOKEN;
    w[NODE_W-1:0] = id;
    return w;
  endfunction

  function automatic logic addressed(node_t dest, node_t me);
    return (dest == me) && (me != '0);
  endfunction
endpackage

// File: rtl/mbn_tx.sv
module mbn_tx
  import mbn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  own_i,
  input  logic  nrdy_i,
  input  logic  tx_valid,
  input  word_t tx_data,
  input  logic  tx_ctrl,
  input  logic  tx_last,
  input  node_t tx_next_id,
  output logic  tx_ready,
  output word_t bus_data_o,
  output logic  bus_valid_o,
  output logic  bus_ctrl_o,
  output logic  bus_rel_o
);
  tx_state_t st_q, st_d;
  word_t hold_q;
  logic  hold_last_q;
  logic  go, load;
  word_t o_data;
  logic  o_valid, o_ctrl, o_rel;

  assign go = !nrdy_i;

  always_comb begin
    st_d = st_q; load = 1'b0;
    o_valid = 1'b0; o_ctrl = 1'b0; o_rel = 1'b0; o_data = '0;
    case (st_q)
      TX_IDLE: if (own_i && tx_valid && go) begin
        o_ctrl = 1'b1;
        st_d = TX_TOKEN;
      end
      TX_TOKEN: if (go && tx_valid) begin
        o_valid = 1'b1;
        o_data = make_token(tx_next_id);
        o_ctrl = tx_ctrl;
        load = 1'b1;
        st_d = TX_BODY;
      end
      TX_BODY: if (go) begin
        if (hold_last_q) begin
          o_valid = 1'b1; o_data = hold_q; o_rel = 1'b1;
          st_d = TX_GAP;
        end else if (tx_valid) begin
          o_valid = 1'b1; o_data = hold_q; o_ctrl = tx_ctrl;
          load = 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  assign tx_ready = load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= TX_IDLE;
      hold_q <= '0; hold_last_q <= 1'b0;
      bus_data_o <= '0; bus_valid_o <= 1'b0; bus_ctrl_o <= 1'b0; bus_rel_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        hold_q <= tx_data;
        hold_last_q <= tx_last;
      end
      bus_data_o <= o_data; bus_valid_o <= o_valid;
      bus_ctrl_o <= o_ctrl; bus_rel_o <= o_rel;
    end
  end

  a_r5_stall_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nrdy_i) |-> !bus_valid_o);
  a_r6_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> $past(own_i));
  a_r4_gap_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rel_o) |-> (!bus_valid_o && !bus_ctrl_o));
  a_r2_token_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && $past(st_q == TX_TOKEN)) |-> (opcode_of(bus_data_o) == OP_TOKEN));
endmodule

// File: rtl/mbn_rx.sv
module mbn_rx
  import mbn_pkg::*;
#(
  parameter int FIRST_OWNER = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  node_t my_id,
  input  word_t bus_data_i,
  input  logic  bus_valid_i,
  input  logic  bus_ctrl_i,
  input  logic  bus_rel_i,
  input  logic  rx_ready,
  output logic  rx_valid,
  output word_t rx_data,
  output logic  bus_nrdy_o,
  output node_t owner_o
);
  logic  pend_q;
  node_t dest_q, next_q, owner_q;
  logic  is_ctrl, is_data, is_rel, tok_hit, sel_hit, for_me;

  assign is_ctrl = bus_valid_i && pend_q;
  assign is_data = bus_valid_i && !pend_q;
  assign is_rel  = bus_valid_i && bus_rel_i;
  assign tok_hit = is_ctrl && (opcode_of(bus_data_i) == OP_TOKEN) && (id_of(bus_data_i) != '0);
  assign sel_hit = is_ctrl && (opcode_of(bus_data_i) == OP_SELECT);
  assign for_me  = addressed(dest_q, my_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dest_q <= '0;
      next_q <= node_t'(FIRST_OWNER);
      owner_q <= node_t'(FIRST_OWNER);
      rx_valid <= 1'b0;
      rx_data <= '0;
    end else begin
      if (bus_ctrl_i) pend_q <= 1'b1;
      else if (bus_valid_i) pend_q <= 1'b0;
      rx_valid <= is_data && for_me;
      if (is_data && for_me) rx_data <= bus_data_i;
      if (tok_hit) next_q <= id_of(bus_data_i);
      if (is_rel) begin
        owner_q <= next_q;
        dest_q <= '0;
      end else if (sel_hit) begin
        dest_q <= id_of(bus_data_i);
      end
    end
  end

  assign bus_nrdy_o = for_me && !rx_ready;
  assign owner_o = owner_q;

  a_r9_owner_moves_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != $past(owner_q)) |-> $past(is_rel));
  a_r10_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_rel) |-> (dest_q == '0));
  a_r8_from_data_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bus_valid_i && !pend_q));
  a_r11_nrdy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nrdy_o |-> (dest_q != '0));
endmodule

// File: rtl/media_bus_node.sv
module media_bus_node
  import mbn_pkg::*;
#(
  parameter int FIRST_OWNER = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] my_id,
  input  logic              tx_valid,
  input  logic [BUS_W-1:0]  tx_data,
  input  logic              tx_ctrl,
  input  logic              tx_last,
  input  logic [NODE_W-1:0] tx_next_id,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BUS_W-1:0]  rx_data,
  input  logic              rx_ready,
  input  logic [BUS_W-1:0]  bus_data_i,
  input  logic              bus_valid_i,
  input  logic              bus_ctrl_i,
  input  logic              bus_rel_i,
  input  logic              bus_nrdy_i,
  output logic [BUS_W-1:0]  bus_data_o,
  output logic              bus_valid_o,
  output logic              bus_ctrl_o,
  output logic              bus_rel_o,
  output logic              bus_nrdy_o,
  output logic [NODE_W-1:0] owner_o
);
  logic own;
  assign own = (owner_o == my_id);

  mbn_tx u_tx (
    .clk(clk), .rst_n(rst_n), .own_i(own), .nrdy_i(bus_nrdy_i),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_last(tx_last),
    .tx_next_id(tx_next_id), .tx_ready(tx_ready),
    .bus_data_o(bus_data_o), .bus_valid_o(bus_valid_o),
    .bus_ctrl_o(bus_ctrl_o), .bus_rel_o(bus_rel_o)
  );

  mbn_rx #(.FIRST_OWNER(FIRST_OWNER)) u_rx (
    .clk(clk), .rst_n(rst_n), .my_id(my_id),
    .bus_data_i(bus_data_i), .bus_valid_i(bus_valid_i), .bus_ctrl_i(bus_ctrl_i),
    .bus_rel_i(bus_rel_i), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .bus_nrdy_o(bus_nrdy_o), .owner_o(owner_o)
  );
endmodule

// File: tb/sim_media_bus_node.sv
module sim_media_bus_node;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [3:0] my_id = 4'd3;
  logic tx_valid = 0, tx_ctrl = 0, tx_last = 0, tx_ready;
  logic [31:0] tx_data = '0;
  logic [3:0] tx_next_id = '0;
  logic rx_valid, rx_ready = 1;
  logic [31:0] rx_data;
  logic [31:0] bb_data = '0, bus_data_o;
  logic bb_valid = 0, bb_ctrl = 0, bb_rel = 0, nrdy_ext = 0;
  logic bus_valid_o, bus_ctrl_o, bus_rel_o, bus_nrdy_o;
  logic [3:0] owner_o;

  media_bus_node u0 (
    .clk(clk), .rst_n(rst_n), .my_id(my_id),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_last(tx_last),
    .tx_next_id(tx_next_id), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .bus_data_i(bus_data_o | bb_data), .bus_valid_i(bus_valid_o | bb_valid),
    .bus_ctrl_i(bus_ctrl_o | bb_ctrl), .bus_rel_i(bus_rel_o | bb_rel),
    .bus_nrdy_i(nrdy_ext | bus_nrdy_o),
    .bus_data_o(bus_data_o), .bus_valid_o(bus_valid_o), .bus_ctrl_o(bus_ctrl_o),
    .bus_rel_o(bus_rel_o), .bus_nrdy_o(bus_nrdy_o), .owner_o(owner_o)
  );

  int checks = 0, errors = 0;
  logic [31:0] exp_rx[$];
  logic [34:0] exp_tx[$];

  task automatic check(bit ok, string req, logic [34:0] act, logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitors: sampled shortly after each rising edge
  always begin
    @(posedge clk); #2;
    if (rst_n) begin
      if (rx_valid) begin
        if (exp_rx.size() == 0) check(0, "R8 unexpected rx word", {3'b0, rx_data}, '0);
        else begin
          logic [31:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R8 rx word", {3'b0, rx_data}, {3'b0, e});
        end
      end
      if (bus_valid_o || bus_ctrl_o) begin
        logic [34:0] a;
        a = {bus_valid_o, bus_ctrl_o, bus_rel_o, bus_data_o};
        if (exp_tx.size() == 0) check(0, "R6 unexpected bus drive", a, '0);
        else begin
          logic [34:0] e;
          e = exp_tx.pop_front();
          check(a == e, "R3 bus event", a, e);
        end
      end
      if (nrdy_ext && bus_valid_o) check(0, "R5 word during not-ready", {34'b0, bus_valid_o}, '0);
    end
  end

  // Bench acts as the other nodes on the bus
  task automatic bus_cycle(bit v, bit c, bit r, logic [31:0] d, bit deliver);
    @(negedge clk);
    bb_valid = v; bb_ctrl = c; bb_rel = r; bb_data = d;
    if (deliver) exp_rx.push_back(d);
  endtask

  task automatic bus_idle();
    bus_cycle(0, 0, 0, '0, 0);
  endtask

  function automatic logic [31:0] tok(logic [3:0] id);
    return {4'h1, 24'h0, id};
  endfunction
  function automatic logic [31:0] sel(logic [3:0] id);
    return {4'h2, 24'h0, id};
  endfunction

  task automatic send_packet(logic [3:0] nxt, int n, logic [31:0] w[4], bit c[4]);
    exp_tx.push_back({1'b0, 1'b1, 1'b0, 32'h0});
    exp_tx.push_back({1'b1, c[0], 1'b0, tok(nxt)});
    for (int i = 0; i < n; i++)
      exp_tx.push_back({1'b1, (i < n-1) ? c[i+1] : 1'b0, (i == n-1), w[i]});
    @(negedge clk);
    tx_next_id = nxt;
    for (int i = 0; i < n; i++) begin
      tx_valid = 1; tx_data = w[i]; tx_ctrl = c[i]; tx_last = (i == n-1);
      forever begin
        #1;
        if (tx_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    tx_valid = 0; tx_last = 0; tx_ctrl = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", '0, '1);
    finish_run();
  end

  initial begin
    logic [31:0] w[4];
    bit c[4];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!bus_valid_o && !bus_ctrl_o && !bus_rel_o && !bus_nrdy_o, "R1 bus idle", {bus_valid_o, bus_ctrl_o, bus_rel_o, 32'h0}, '0);
    check(!rx_valid && !tx_ready, "R1 streams idle", {33'h0, rx_valid, tx_ready}, '0);
    check(owner_o == 4'd1, "R1 owner", {31'h0, owner_o}, 35'd1);
    rst_n = 1;

    // Node 1 packet: selection, unknown opcode, hand-over to node 3
    rx_ready = 0;
    bus_idle(); #1;
    check(!bus_nrdy_o, "R11 nrdy low unselected", {34'h0, bus_nrdy_o}, '0);
    rx_ready = 1;
    bus_cycle(0, 1, 0, '0, 0);           // marker
    bus_cycle(1, 1, 0, tok(4'd3), 0);    // token, next is control
    bus_cycle(1, 0, 0, sel(4'd3), 0);    // select us
    bus_cycle(1, 0, 0, 32'hA000_0001, 1);
    rx_ready = 0; #1;
    check(bus_nrdy_o, "R11 nrdy when selected and sink busy", {34'h0, bus_nrdy_o}, 35'd1);
    bus_cycle(1, 1, 0, 32'hA000_0002, 1); // R11 still delivered
    rx_ready = 1;
    bus_cycle(1, 0, 0, sel(4'd9), 0);
    bus_cycle(1, 0, 0, 32'hB000_0003, 0);
    bus_cycle(0, 1, 0, '0, 0);           // R7 marker on empty cycle
    bus_idle();
    bus_cycle(1, 0, 0, 32'h7000_0003, 0); // R12 unknown opcode
    bus_cycle(1, 1, 0, 32'hB000_0004, 0); // still dest 9
    bus_cycle(1, 0, 0, sel(4'd3), 0);
    bus_cycle(1, 0, 1, 32'hA000_0005, 1); // release
    bus_idle(); #1;
    check(owner_o == 4'd3, "R9 owner after release", {31'h0, owner_o}, 35'd3);
    check(exp_rx.size() == 0, "R8 all addressed words seen", exp_rx.size(), 0);

    // R2 R3 R4 R5: this node sends, with a stall in the middle
    w[0] = 32'hC000_0001; c[0] = 0;
    w[1] = 32'hC000_0002; c[1] = 0;
    w[2] = 32'h7000_0003; c[2] = 1;
    w[3] = 32'hC000_0004; c[3] = 0;
    fork
      send_packet(4'd5, 4, w, c);
      begin
        repeat (4) @(negedge clk);
        nrdy_ext = 1;
        repeat (3) @(negedge clk);
        nrdy_ext = 0;
      end
    join
    repeat (3) @(negedge clk); #1;
    check(exp_tx.size() == 0, "R3 all words sent", exp_tx.size(), 0);
    check(owner_o == 4'd5, "R9 owner after own release", {31'h0, owner_o}, 35'd5);

    // R6: wait while not owner; node 5 runs; R10, R9 zero-ID token
    w[0] = 32'hD000_0001; c[0] = 0;
    fork
      send_packet(4'd1, 1, w, c);
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk); #1;
          check(!bus_valid_o && !bus_ctrl_o && !tx_ready, "R6 silent when not owner",
                {bus_valid_o, bus_ctrl_o, tx_ready, 32'h0}, '0);
        end
        bus_cycle(0, 1, 0, '0, 0);
        bus_cycle(1, 0, 0, tok(4'd0), 0);     // ignored token
        bus_cycle(1, 0, 1, 32'hE000_0001, 0); // R10 no selection
        bus_idle(); #1;
        check(owner_o == 4'd5, "R9 zero-ID token ignored", {31'h0, owner_o}, 35'd5);
        bus_cycle(0, 1, 0, '0, 0);
        bus_cycle(1, 0, 0, tok(4'd3), 0);
        bus_cycle(1, 0, 1, 32'hE000_0002, 0);
        bus_idle();
      end
    join
    repeat (4) @(negedge clk); #1;
    check(exp_tx.size() == 0, "R2 second packet sent", exp_tx.size(), 0);
    check(owner_o == 4'd1, "R9 owner back to 1", {31'h0, owner_o}, 35'd1);
    check(exp_rx.size() == 0, "R10 no stray delivery", exp_rx.size(), 0);
    finish_run();
  end
endmodule